// File: doc/BRIEF.md
# SECDED Memory Scrubbing Engine

This block holds a small on-chip memory of data words. Each word is stored together with Hamming check bits and one overall parity bit, which gives single-error correction and double-error detection (SECDED). Every host read is decoded as it happens. The response carries the corrected data and a status code that says whether the word was clean, was corrected, or could not be corrected. The stored array is modelled inside the block as a register file with one access per cycle.

Soft errors are normally found only when a word is read, so an autonomous scrubber walks through the addresses in the background. It reads one word every programmable number of cycles. When it finds a correctable error, it writes the repaired word and fresh check bits back in the following cycle. Host traffic always wins the single array port, and a scrub read-modify-write is never interleaved with a host access. Saturating counters record corrected and uncorrectable events. A sticky flag and an address register keep track of the latest uncorrectable word.

A host write can XOR an injection mask into the stored codeword. This lets integration tests plant single, double and check-bit faults through the normal port.

Top module: `secded_scrub_top`

## Requirements
- R1: A host read accepted in one cycle (req_valid and req_ready high at a rising edge) gives rsp_valid high in the next cycle with the stored data. A clean word returns status 2'b00. Writes produce no response.
- R2: A word with exactly one flipped bit, in a data or a Hamming check position, returns the original data with status 2'b01.
- R3: A word with two flipped bits returns status 2'b10 and the uncorrected data. It raises unc_seen, which stays high until reset, and loads its address into unc_addr.
- R4: A word whose only fault is the overall parity bit returns its data unchanged with status 2'b01, and the scrubber rewrites it with correct parity.
- R5: With scrub_interval = N > 0, a scrub read becomes due every N cycles. When the scrub read finds a correctable error, the corrected word is written back, so a later host read of that address returns status 2'b00. N = 0 stops scrubbing.
- R6: The scrub address rises by one for each scrub read and returns to 0 after DEPTH-1, so sweeps repeat for as long as scrubbing is enabled.
- R7: A scrub read is issued only in a cycle with req_valid low. req_ready is low for exactly the one writeback cycle that follows a correcting scrub read, and high at all other times.
- R8: corr_count counts every read (host or scrub) with status 2'b01. unc_count counts every read with status 2'b10. Each counter rises by at most one per cycle and holds at its all-ones value.
- R9: A host write stores the encoded word XOR req_inject. Codeword bit 0 is the overall parity bit. Bit j (1 to 71) is Hamming position j. Positions that are powers of two hold check bits. Data bits fill the other positions in ascending order: data bit 0 at position 3, data bit 1 at 5, data bit 4 at 9.
- R10: After reset, the counters, unc_seen and rsp_valid are zero, req_ready is high, and every word reads as zero data with status 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_inject | input | CW | Fault mask XORed into the stored codeword on writes |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | DATA_W | Corrected read data |
| rsp_status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| scrub_interval | input | IVL_W | Cycles between scrub reads, 0 disables |
| corr_count | output | CNT_W | Saturating corrected-event count |
| unc_count | output | CNT_W | Saturating uncorrectable-event count |
| unc_seen | output | 1 | Sticky uncorrectable flag |
| unc_addr | output | ADDR_W | Address of the latest uncorrectable word |

## Verification
The bench builds the block with DATA_W = 64, DEPTH = 8, IVL_W = 8 and CNT_W = 4. The full 72-bit codeword layout is exercised, and with only eight words a complete scrub sweep at an interval of 4 finishes in about 32 cycles, so several wraps fit in a short run. The 4-bit counters reach their saturation value of 15 after a handful of deliberate fault reads. A scrub interval of 1 combined with back-to-back host reads shows that the scrubber is starved while the host is active and catches up once the host goes idle.

// File: rtl/secded_scrub_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the SECDED scrubbing engine.
// Assumes check-bit count is derived from the data width at elaboration.
package secded_scrub_pkg;

    typedef enum logic [1:0] {
        ST_OK   = 2'b00,
        ST_CORR = 2'b01,
        ST_UNC  = 2'b10
    } ecc_status_e;

    // Smallest Hamming check-bit count p with 2^p >= dw + p + 1.
    function automatic int hamming_bits(input int dw);
        int p;
        p = 1;
        while ((1 << p) < (dw + p + 1)) p++;
        return p;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
`timescale 1ns/1ps
// Builds a SECDED codeword: bit 0 = overall parity, bits 1..N = Hamming
// positions, check bits at power-of-two positions, data in the rest ascending.
// Assumes purely combinational use.
module secded_encoder
    import secded_scrub_pkg::*;
#(
    parameter  int DATA_W = 64,
    localparam int CHK_W  = hamming_bits(DATA_W),
    localparam int HAM_N  = DATA_W + CHK_W,
    localparam int CW     = HAM_N + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW-1:0]     code_o
);

    logic [CW-1:0] c;
    logic          b;
    int            k;

    // Place data, compute check bits, then overall parity.
    always_comb begin
        c = '0;
        k = 0;
        b = 1'b0;
        for (int j = 1; j <= HAM_N; j++) begin
            if ((j & (j - 1)) != 0) begin
                c[j] = data_i[k];
                k++;
            end
        end
        for (int i = 0; i < CHK_W; i++) begin
            b = 1'b0;
            for (int j = 1; j <= HAM_N; j++) begin
                if (((j >> i) & 1) == 1) b = b ^ c[j];
            end
            c[1 << i] = b;
        end
        c[0]   = ^c[HAM_N:1];
        code_o = c;
    end

endmodule

// File: rtl/secded_decoder.sv
`timescale 1ns/1ps
// Checks a SECDED codeword, repairs a single flipped bit and classifies the
// result. Assumes the layout produced by secded_encoder.
module secded_decoder
    import secded_scrub_pkg::*;
#(
    parameter  int DATA_W = 64,
    localparam int CHK_W  = hamming_bits(DATA_W),
    localparam int HAM_N  = DATA_W + CHK_W,
    localparam int CW     = HAM_N + 1
) (
    input  logic [CW-1:0]     code_i,
    output logic [DATA_W-1:0] data_o,
    output ecc_status_e       status_o
);

    logic [CHK_W-1:0] syn;
    logic             par_fail;
    logic [CW-1:0]    fixed;
    int               k;

    // Syndrome and overall parity of the stored word.
    always_comb begin
        syn = '0;
        for (int j = 1; j <= HAM_N; j++) begin
            if (code_i[j]) syn = syn ^ j[CHK_W-1:0];
        end
        par_fail = ^code_i;
    end

    // Classify, repair a single error and extract the data bits.
    always_comb begin
        fixed    = code_i;
        status_o = ST_OK;
        if (syn == '0) begin
            if (par_fail) status_o = ST_CORR;
        end else if (par_fail) begin
            if (int'(syn) <= HAM_N) begin
                fixed[syn] = ~fixed[syn];
                status_o   = ST_CORR;
            end else begin
                status_o = ST_UNC;
            end
        end else begin
            status_o = ST_UNC;
        end
        k      = 0;
        data_o = '0;
        for (int j = 1; j <= HAM_N; j++) begin
            if ((j & (j - 1)) != 0) begin
                data_o[k] = fixed[j];
                k++;
            end
        end
    end

endmodule

// File: rtl/secded_scrub_sched.sv
`timescale 1ns/1ps
// Background scrub walker: raises one due scrub read every scrub_interval
// cycles, issues it only when the host is idle, walks addresses with wrap and
// schedules a one-cycle writeback when the read found a correctable error.
// Assumes DEPTH >= 2.
module secded_scrub_sched #(
    parameter  int DEPTH  = 16,
    parameter  int IVL_W  = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IVL_W-1:0]  interval,
    input  logic              host_busy,
    input  logic              corr_found,
    output logic              scrub_go,
    output logic [ADDR_W-1:0] scrub_addr,
    output logic              wb_active,
    output logic [ADDR_W-1:0] wb_addr
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [IVL_W-1:0] cnt;
    logic [IVL_W-1:0] cnt_nxt;
    logic             pending;
    logic             fire;

    assign cnt_nxt  = cnt + IVL_W'(1);
    assign fire     = (interval != '0) && (cnt_nxt >= interval);
    assign scrub_go = pending && !host_busy && !wb_active;

    // Interval timer and due flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else if (interval == '0) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            cnt     <= fire ? '0 : cnt_nxt;
            pending <= (pending && !scrub_go) || fire;
        end
    end

    // Address walker with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scrub_addr <= '0;
        end else if (scrub_go) begin
            scrub_addr <= (scrub_addr == LAST) ? '0 : scrub_addr + ADDR_W'(1);
        end
    end

    // Writeback slot following a correcting scrub read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_active <= 1'b0;
            wb_addr   <= '0;
        end else begin
            wb_active <= scrub_go && corr_found;
            if (scrub_go) wb_addr <= scrub_addr;
        end
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (scrub_go && scrub_addr == LAST) |=> (scrub_addr == '0)); // R6
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(scrub_addr) < DEPTH)); // R6
    AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_active |=> !wb_active); // R7
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (interval == '0) |=> !scrub_go); // R5

endmodule

// File: rtl/secded_err_log.sv
`timescale 1ns/1ps
// Saturating event counters and uncorrectable-error capture.
// Assumes at most one decode event per cycle.
module secded_err_log
    import secded_scrub_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  ecc_status_e       ev_status,
    input  logic [ADDR_W-1:0] ev_addr,
    output logic [CNT_W-1:0]  corr_cnt,
    output logic [CNT_W-1:0]  unc_cnt,
    output logic              ue_flag,
    output logic [ADDR_W-1:0] ue_addr
);

    // Corrected-event counter, holds at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_cnt <= '0;
        end else if (ev_valid && ev_status == ST_CORR && corr_cnt != '1) begin
            corr_cnt <= corr_cnt + CNT_W'(1);
        end
    end

    // Uncorrectable counter plus sticky flag and address capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unc_cnt <= '0;
            ue_flag <= 1'b0;
            ue_addr <= '0;
        end else if (ev_valid && ev_status == ST_UNC) begin
            if (unc_cnt != '1) unc_cnt <= unc_cnt + CNT_W'(1);
            ue_flag <= 1'b1;
            ue_addr <= ev_addr;
        end
    end

    AST_CORR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_cnt == '1) |=> (corr_cnt == '1)); // R8
    AST_UNC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (unc_cnt == '1) |=> (unc_cnt == '1)); // R8
    AST_CORR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(corr_cnt) |-> (corr_cnt == $past(corr_cnt) + CNT_W'(1))); // R8
    AST_UE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ue_flag |=> ue_flag); // R3

endmodule

// File: rtl/secded_scrub_top.sv
`timescale 1ns/1ps
// SECDED-protected word memory with a background scrubber. One array port is
// shared: host requests win, scrub reads fill idle cycles, and a correcting
// scrub read is followed by a writeback cycle during which the host waits.
// Assumes DEPTH >= 2 and a register-file array that reads combinationally.
module secded_scrub_top
    import secded_scrub_pkg::*;
#(
    parameter  int DATA_W = 64,
    parameter  int DEPTH  = 16,
    parameter  int IVL_W  = 16,
    parameter  int CNT_W  = 8,
    localparam int CHK_W  = hamming_bits(DATA_W),
    localparam int CW     = DATA_W + CHK_W + 1,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CW-1:0]     req_inject,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        rsp_status,
    input  logic [IVL_W-1:0]  scrub_interval,
    output logic [CNT_W-1:0]  corr_count,
    output logic [CNT_W-1:0]  unc_count,
    output logic              unc_seen,
    output logic [ADDR_W-1:0] unc_addr
);

    logic [CW-1:0]     mem [DEPTH];
    logic              host_acc;
    logic              host_rd;
    logic              scrub_go;
    logic              wb_active;
    logic [ADDR_W-1:0] scrub_addr;
    logic [ADDR_W-1:0] wb_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [CW-1:0]     rd_code;
    logic [DATA_W-1:0] dec_data;
    ecc_status_e       dec_status;
    logic [DATA_W-1:0] enc_in;
    logic [CW-1:0]     enc_code;
    logic [DATA_W-1:0] wb_data;
    ecc_status_e       rsp_status_q;

    assign req_ready = !wb_active;
    assign host_acc  = req_valid && req_ready;
    assign host_rd   = host_acc && !req_write;
    assign rd_addr   = host_acc ? req_addr : scrub_addr;
    assign rd_code   = mem[rd_addr];
    assign enc_in    = wb_active ? wb_data : req_wdata;
    assign rsp_status = rsp_status_q;

    secded_decoder #(.DATA_W(DATA_W)) u_dec (
        .code_i   (rd_code),
        .data_o   (dec_data),
        .status_o (dec_status)
    );

    secded_encoder #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_in),
        .code_o (enc_code)
    );

    secded_scrub_sched #(.DEPTH(DEPTH), .IVL_W(IVL_W)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .interval   (scrub_interval),
        .host_busy  (req_valid),
        .corr_found (dec_status == ST_CORR),
        .scrub_go   (scrub_go),
        .scrub_addr (scrub_addr),
        .wb_active  (wb_active),
        .wb_addr    (wb_addr)
    );

    secded_err_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (host_rd || scrub_go),
        .ev_status (dec_status),
        .ev_addr   (rd_addr),
        .corr_cnt  (corr_count),
        .unc_cnt   (unc_count),
        .ue_flag   (unc_seen),
        .ue_addr   (unc_addr)
    );

    // Array writes: scrub writeback or host write with fault mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wb_active) begin
            mem[wb_addr] <= enc_code;
        end else if (host_acc && req_write) begin
            mem[req_addr] <= enc_code ^ req_inject;
        end
    end

    // Hold corrected scrub data for the writeback cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) wb_data <= '0;
        else if (scrub_go) wb_data <= dec_data;
    end

    // Register the host read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            rsp_status_q <= ST_OK;
        end else begin
            rsp_valid <= host_rd;
            if (host_rd) begin
                rsp_rdata    <= dec_data;
                rsp_status_q <= dec_status;
            end
        end
    end

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid); // R1
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> !rsp_valid); // R1
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready); // R7
    AST_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(!req_valid)); // R7

endmodule

// File: tb/secded_scrub_top_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected read responses, a monitor
// compares them as responses appear; counters are checked against a model.
module secded_scrub_top_bench;

    localparam int DW = 64;
    localparam int DP = 8;
    localparam int IW = 8;
    localparam int CN = 4;
    localparam int CWB = 72;
    localparam int CMAX = 15;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [2:0]      req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic [CWB-1:0]  req_inject = '0;
    logic            rsp_valid;
    logic [DW-1:0]   rsp_rdata;
    logic [1:0]      rsp_status;
    logic [IW-1:0]   scrub_interval = '0;
    logic [CN-1:0]   corr_count;
    logic [CN-1:0]   unc_count;
    logic            unc_seen;
    logic [2:0]      unc_addr;

    int checks = 0;
    int fails  = 0;
    int exp_corr = 0;
    int exp_unc  = 0;
    logic [DW+1:0] exp_q [$];

    localparam logic [CWB-1:0] INJ_1  = 72'h20;           // position 5 (data bit 1)
    localparam logic [CWB-1:0] INJ_2  = 72'h220;          // positions 5 and 9
    localparam logic [CWB-1:0] INJ_P  = 72'h1;            // overall parity bit
    localparam logic [CWB-1:0] INJ_CK = 72'h2;            // check bit at position 1

    always #2.5 clk = ~clk;

    secded_scrub_top #(.DATA_W(DW), .DEPTH(DP), .IVL_W(IW), .CNT_W(CN)) u_secded_scrub_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_inject(req_inject), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_status(rsp_status), .scrub_interval(scrub_interval),
        .corr_count(corr_count), .unc_count(unc_count), .unc_seen(unc_seen),
        .unc_addr(unc_addr)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    // Monitor: pop and compare each read response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected response", {62'd0, rsp_status}, 64'd0);
            end else begin
                logic [DW+1:0] e;
                e = exp_q.pop_front();
                check(rsp_rdata == e[DW+1:2], "R1/R2/R3/R4 rsp data", rsp_rdata, e[DW+1:2]);
                check(rsp_status == e[1:0], "R1/R2/R3/R4 rsp status", {62'd0, rsp_status}, {62'd0, e[1:0]});
            end
        end
    end

    task automatic host_req(input logic wr, input logic [2:0] a, input logic [DW-1:0] d, input logic [CWB-1:0] inj);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_addr   = a;
        req_wdata  = d;
        req_inject = inj;
        @(negedge clk);
        req_valid  = 1'b0;
        req_inject = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d, input logic [CWB-1:0] inj);
        host_req(1'b1, a, d, inj);
    endtask

    task automatic rd(input logic [2:0] a, input logic [DW-1:0] ed, input logic [1:0] es);
        exp_q.push_back({ed, es});
        host_req(1'b0, a, '0, '0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_counts(input string tag);
        check(int'(corr_count) == sat(exp_corr), {tag, " corr_count"}, 64'(corr_count), 64'(sat(exp_corr)));
        check(int'(unc_count) == sat(exp_unc), {tag, " unc_count"}, 64'(unc_count), 64'(sat(exp_unc)));
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_test();
    end

    initial begin
        int lows;
        logic [DW-1:0] d0 = 64'h0123_4567_89AB_CDEF;
        logic [DW-1:0] d1 = 64'hDEAD_BEEF_0BAD_F00D;
        logic [DW-1:0] d2 = 64'hFFFF_0000_A5A5_5A5A;
        logic [DW-1:0] d3 = 64'h1357_9BDF_2468_ACE0;
        logic [DW-1:0] d4 = 64'h8000_0000_0000_0001;

        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R10: reset state
        check(rsp_valid == 1'b0, "R10 rsp_valid", 64'(rsp_valid), 0);
        check(req_ready == 1'b1, "R10 req_ready", 64'(req_ready), 1);
        check(unc_seen == 1'b0, "R10 unc_seen", 64'(unc_seen), 0);
        check_counts("R10");
        rd(3'd0, 64'd0, 2'b00);                     // R10 zeroed array

        // R1 clean, R2/R9 single data error, R3 double, R4 parity, R9 check bit
        wr(3'd1, d0, '0);    rd(3'd1, d0, 2'b00);
        wr(3'd2, d1, INJ_1); rd(3'd2, d1, 2'b01);   exp_corr++;
        wr(3'd3, d2, INJ_2); rd(3'd3, d2 ^ 64'h12, 2'b10); exp_unc++;
        wr(3'd4, d3, INJ_P); rd(3'd4, d3, 2'b01);   exp_corr++;
        wr(3'd5, d4, INJ_CK); rd(3'd5, d4, 2'b01);  exp_corr++;
        idle(2);
        check_counts("R2/R3/R4");
        check(unc_seen == 1'b1, "R3 unc_seen", 64'(unc_seen), 1);
        check(unc_addr == 3'd3, "R3 unc_addr", 64'(unc_addr), 3);
        wr(3'd3, d2, '0);                           // clean the double-error word

        // R5/R4: scrubber repairs words 2, 4, 5
        scrub_interval = 8'd4;
        idle(80);
        exp_corr += 3;
        scrub_interval = 8'd0;
        idle(3);
        check_counts("R5 scrub repair");
        check(unc_seen == 1'b1, "R3 unc_seen sticky", 64'(unc_seen), 1);
        rd(3'd2, d1, 2'b00);
        rd(3'd4, d3, 2'b00);
        rd(3'd5, d4, 2'b00);
        idle(2);
        check_counts("R5 no recount");

        // R6: later sweep returns to address 0
        wr(3'd0, d3, INJ_1);
        scrub_interval = 8'd4;
        idle(80);
        exp_corr++;
        scrub_interval = 8'd0;
        idle(3);
        check_counts("R6 wrap");
        rd(3'd0, d3, 2'b00);

        // R7: host traffic starves the scrubber
        wr(3'd6, d0, INJ_1);
        scrub_interval = 8'd1;
        for (int i = 0; i < 20; i++) rd(3'd1, d0, 2'b00);
        check_counts("R7 starved");
        lows = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!req_ready) lows++;
        end
        exp_corr++;
        check(lows == 1, "R7 ready low cycles", 64'(lows), 1);
        scrub_interval = 8'd0;
        idle(3);
        check_counts("R7 resumed");

        // R8: saturation of both counters
        wr(3'd6, d1, INJ_1);
        for (int i = 0; i < 10; i++) begin
            rd(3'd6, d1, 2'b01);
            exp_corr++;
        end
        wr(3'd7, d2, INJ_2);
        for (int i = 0; i < 16; i++) begin
            rd(3'd7, d2 ^ 64'h12, 2'b10);
            exp_unc++;
        end
        idle(3);
        check(corr_count == 4'hF, "R8 corr saturated", 64'(corr_count), 15);
        check(unc_count == 4'hF, "R8 unc saturated", 64'(unc_count), 15);
        check(unc_addr == 3'd7, "R3 unc_addr update", 64'(unc_addr), 7);
        check(exp_q.size() == 0, "R1 all responses seen", 64'(exp_q.size()), 0);
        finish_test();
    end

endmodule